// File: doc/BRIEF.md
# Set/Clear Parallel Output Port with Synchronized Input Port

This block is the general-purpose parallel I/O section of a serial controller. It drives a bank of output pins, typically used as modem-control lines (data-terminal-ready, request-to-send, a line-driver direction enable). It also returns the level of a bank of active-low input pins. The host never performs a read-modify-write to change one output line. It writes a mask to a set address to raise bits of the output register, and a mask to a clear address to drop them. Bits whose mask bit is zero are untouched.

A per-pin configuration register chooses, for each pin, between the output register (general-purpose use) and a special-function source that lives outside the block and arrives on `sf_in`. Each pin carries the complement of its selected source, so an asserted line pulls the pin low. The input pins are active low and pass through a synchronizer before they reach the read path. Only the low four address bits are decoded, so the bank repeats through the bus address space.

Top module: `pio_port`

## Requirements
- R1: A write to decoded address 0xE sets every output-register bit whose write-data bit is 1 and leaves all other bits unchanged.
- R2: A write to decoded address 0xF clears every output-register bit whose write-data bit is 1 and leaves all other bits unchanged.
- R3: The output register does not change on cycles without a write to 0xE or 0xF, including writes to 0xD and to unused addresses.
- R4: A write to decoded address 0xD loads the configuration register with the write data; a configuration value of zero puts every pin under output-register control.
- R5: For pin i, `pin_out[i]` is the complement of output-register bit i when configuration bit i is 0, and the complement of `sf_in[i]` when configuration bit i is 1; a change on `sf_in` reaches the pin in the same cycle.
- R6: After reset the output register and configuration register are zero, so every `pin_out` bit is 1.
- R7: With decoded address 0xD on the bus, `bus_rdata` returns the raw input-pin levels (a low pin reads 0, meaning asserted) after two clock edges of synchronization; after only one edge the old value is still returned.
- R8: Only `bus_addr[3:0]` is decoded; the upper address bits have no effect on which register a write or read selects.
- R9: `bus_rdata` is zero when the decoded address is anything other than 0xD.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | BUS_AW (8) | Register address; low 4 bits decoded |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | WIDTH (8) | Write data / bit mask |
| bus_rdata | output | WIDTH (8) | Read data, combinational from address |
| sf_in | input | WIDTH (8) | Special-function sources, active high |
| pin_in | input | WIDTH (8) | Input pins, active low, asynchronous |
| pin_out | output | WIDTH (8) | Output pins, complement of selected source |

## Verification
The bench sets and clears overlapping masks. A design that assigned the mask instead of merging it would wipe bits set earlier, and an all-zero clear mask must leave the register intact. It writes through aliased addresses with nonzero upper bits, so a decoder that looked at the full address would ignore those writes. It switches some pins to special-function drive, then moves `sf_in`, which catches a mux that inverted the wrong source or registered it. It checks the input read one edge and two edges after a pin change, so a synchronizer with one stage too few or too many shows up as a wrong value.

// File: rtl/pio_pkg.sv
package pio_pkg;

   localparam int DEC_AW = 4;

   typedef logic [DEC_AW-1:0] dec_addr_t;

   localparam dec_addr_t A_INCFG = 4'hD;
   localparam dec_addr_t A_SET   = 4'hE;
   localparam dec_addr_t A_CLR   = 4'hF;

   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_SET  = 2'd1,
      OP_CLR  = 2'd2,
      OP_CFG  = 2'd3
   } wr_op_e;

   function automatic wr_op_e decode_wr(input logic we, input dec_addr_t a);
      if (!we) return OP_NONE;
      case (a)
         A_SET:   return OP_SET;
         A_CLR:   return OP_CLR;
         A_INCFG: return OP_CFG;
         default: return OP_NONE;
      endcase
   endfunction

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [STAGES-1:0][WIDTH-1:0] stg;

   // stage 0 captures the pin; the idle (released) level is all ones
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= '1;
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/pio_outreg.sv
module pio_outreg
   import pio_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  wr_op_e           op,
   input  logic [WIDTH-1:0] mask,
   output logic [WIDTH-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         case (op)
            OP_SET:  q <= q | mask;
            OP_CLR:  q <= q & ~mask;
            default: q <= q;
         endcase
      end
   end

   // R1: masked bits become 1, unmasked bits keep their value
   p_set_merge_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_SET) |=> (((q & $past(mask)) == $past(mask)) &&
                          ((q & ~$past(mask)) == ($past(q) & ~$past(mask)))));

   // R2: masked bits become 0, unmasked bits keep their value
   p_clr_merge_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_CLR) |=> (((q & $past(mask)) == '0) &&
                          ((q | $past(mask)) == ($past(q) | $past(mask)))));

   // R3: no set/clear write, no change
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((op != OP_SET) && (op != OP_CLR)) |=> $stable(q));

endmodule

// File: rtl/pio_outmux.sv
module pio_outmux #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] cfg,
   input  logic [WIDTH-1:0] gp,
   input  logic [WIDTH-1:0] sf,
   output logic [WIDTH-1:0] pins
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic src;
      assign src     = cfg[i] ? sf[i] : gp[i];
      assign pins[i] = ~src;
   end

endmodule

// File: rtl/pio_port.sv
module pio_port
   import pio_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int BUS_AW      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BUS_AW-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [WIDTH-1:0]  bus_wdata,
   output logic [WIDTH-1:0]  bus_rdata,
   input  logic [WIDTH-1:0]  sf_in,
   input  logic [WIDTH-1:0]  pin_in,
   output logic [WIDTH-1:0]  pin_out
);

   if (WIDTH < 1 || WIDTH > 32) begin : g_bad_width
      $error("pio_port: WIDTH must be 1..32");
   end
   if (BUS_AW < DEC_AW) begin : g_bad_aw
      $error("pio_port: BUS_AW narrower than decoded address");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pio_port: SYNC_STAGES must be at least 2");
   end

   dec_addr_t        dec_a;
   wr_op_e           op;
   logic [WIDTH-1:0] cfg_q;
   logic [WIDTH-1:0] opr_q;
   logic [WIDTH-1:0] in_sync;

   // upper address bits are dropped before any decoding
   assign dec_a = bus_addr[DEC_AW-1:0];
   assign op    = decode_wr(bus_we, dec_a);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cfg_q <= '0;
      else if (op == OP_CFG) cfg_q <= bus_wdata;
   end

   pio_outreg #(.WIDTH(WIDTH)) u_oreg (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (op),
      .mask  (bus_wdata),
      .q     (opr_q)
   );

   pio_outmux #(.WIDTH(WIDTH)) u_omux (
      .cfg  (cfg_q),
      .gp   (opr_q),
      .sf   (sf_in),
      .pins (pin_out)
   );

   pio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_isync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (in_sync)
   );

   assign bus_rdata = (dec_a == A_INCFG) ? in_sync : '0;

   // R4: configuration write lands on the next edge
   p_cfg_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_CFG) |=> (cfg_q == $past(bus_wdata)));

   // R5: with no special functions selected the pins mirror the output register
   p_gpio_pins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q == '0) |-> (pin_out == ~opr_q));

   // R7: two-flop latency, checked once two edges have passed since reset
   if (SYNC_STAGES == 2) begin : g_lat_chk
      logic [1:0] age;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          age <= '0;
         else if (age != 2'd3) age <= age + 2'd1;
      end
      p_sync_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (age >= 2'd2) |-> (in_sync == $past(pin_in, 2)));
   end

endmodule

// File: tb/sim_pio_port.sv
module sim_pio_port;

   localparam int PER = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] bus_addr = 8'h00;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic [7:0] sf_in = 8'h00;
   logic [7:0] pin_in = 8'hFF;
   logic [7:0] pin_out;

   always #(PER/2) clk = ~clk;

   pio_port u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .sf_in     (sf_in),
      .pin_in    (pin_in),
      .pin_out   (pin_out)
   );

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   // scoreboard queues: kind 0 = pin_out, kind 1 = bus_rdata
   int         q_kind[$];
   logic [7:0] q_exp[$];
   string      q_tag[$];

   // bench model
   logic [7:0] opr_m = 8'h00;
   logic [7:0] cfg_m = 8'h00;

   function automatic logic [7:0] pins_exp();
      return ~((opr_m & ~cfg_m) | (sf_in & cfg_m));
   endfunction

   task automatic push(input int kind, input logic [7:0] exp, input string tag);
      q_kind.push_back(kind);
      q_exp.push_back(exp);
      q_tag.push_back(tag);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_we    = 1'b1;
      bus_addr  = a;
      bus_wdata = d;
      @(negedge clk);
      bus_we    = 1'b0;
      bus_addr  = 8'h00;
      bus_wdata = 8'h00;
      case (a[3:0])
         4'hE: opr_m = opr_m | d;
         4'hF: opr_m = opr_m & ~d;
         4'hD: cfg_m = d;
         default: ;
      endcase
   endtask

   // monitor: compares queued expectations a quarter period after each falling edge
   initial begin
      forever begin
         @(negedge clk);
         #(PER/4);
         while (q_kind.size() > 0) begin
            int         k;
            logic [7:0] e;
            logic [7:0] act;
            string      t;
            k = q_kind.pop_front();
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            act = (k == 0) ? pin_out : bus_rdata;
            total++;
            if (act !== e) begin
               bad++;
               $display("FAIL %s: %s actual=%h expected=%h", t,
                        (k == 0) ? "pin_out" : "bus_rdata", act, e);
            end
         end
      end
   end

   initial begin
      #(PER * 200000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R6: reset state
      push(0, 8'hFF, "R6 pins high after reset");
      bus_addr = 8'h0D;
      push(1, 8'hFF, "R6 input sync idle");
      @(negedge clk);
      bus_addr = 8'h00;

      // R1: set merges
      wr(8'h0E, 8'h05); push(0, pins_exp(), "R1 set 05");
      wr(8'h0E, 8'h30); push(0, pins_exp(), "R1 set 30 keeps 05");
      // R2: clear merges
      wr(8'h0F, 8'h01); push(0, pins_exp(), "R2 clear 01");
      wr(8'h0F, 8'h00); push(0, pins_exp(), "R2 empty mask no change");
      // R3: unrelated writes and idle cycles
      wr(8'h03, 8'hFF); push(0, pins_exp(), "R3 unused address write");
      repeat (3) @(negedge clk);
      push(0, pins_exp(), "R3 idle cycles");
      wr(8'h0D, 8'h00); push(0, pins_exp(), "R3 config write leaves output reg");
      // R8: aliases through upper address bits
      wr(8'h1E, 8'h80); push(0, pins_exp(), "R8 set via 1E");
      wr(8'hAF, 8'h04); push(0, pins_exp(), "R8 clear via AF");
      // R4/R5: special-function selection
      sf_in = 8'h0F;
      wr(8'h0D, 8'h0F); push(0, pins_exp(), "R4 config 0F selects sf");
      @(negedge clk);
      sf_in = 8'h05;
      push(0, pins_exp(), "R5 sf change reaches pins");
      @(negedge clk);
      wr(8'h5D, 8'hF0); push(0, pins_exp(), "R5 upper pins to sf via 5D");
      wr(8'h0D, 8'h00); push(0, pins_exp(), "R4 zero config all gpio");
      push(0, ~opr_m, "R4 pins follow output reg");

      // R7: two-edge synchronizer latency
      @(negedge clk);
      pin_in   = 8'h5A;
      bus_addr = 8'h0D;
      push(1, 8'hFF, "R7 no edge yet");
      @(negedge clk);
      push(1, 8'hFF, "R7 one edge still old");
      @(negedge clk);
      push(1, 8'h5A, "R7 two edges new value");
      @(negedge clk);
      bus_addr = 8'h7D;
      push(1, 8'h5A, "R8 read alias 7D");
      @(negedge clk);
      bus_addr = 8'h03;
      push(1, 8'h00, "R9 unused address reads zero");
      @(negedge clk);
      bus_addr = 8'h0E;
      push(1, 8'h00, "R9 set address reads zero");

      // R6: reset mid-run
      @(negedge clk);
      bus_addr = 8'h00;
      sf_in = 8'h00;
      wr(8'h0E, 8'hC3);
      wr(8'h0D, 8'h11);
      rst_n = 1'b0;
      opr_m = 8'h00;
      cfg_m = 8'h00;
      sf_in = 8'hFF;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      push(0, 8'hFF, "R6 reset clears output and config");

      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule